// File: doc/BRIEF.md
# Programmable Duty-Cycle Pulse Channel

This block produces a square-wave tone with a selectable duty cycle. A CPU-side write port loads a 2-bit duty select, an 11-bit period (written as an 8-bit low part and a 3-bit high part), and restarts the waveform. An 11-bit down-counting timer advances once every second system clock. Each time it reaches zero it reloads the period and steps an 8-position duty sequencer. The sequencer walks its position downward from zero.

The envelope generator, sweep unit and length counter sit outside this block. It sees them only through ports: a 4-bit volume, a length-active flag, a sweep mute flag, and a sweep period-update path that overwrites the stored period. The block drives a one-cycle restart pulse back to the envelope generator whenever the high period part is written. The 4-bit output is the volume when the channel is sounding and zero otherwise.

The write port is a plain strobe with no back-pressure: every cycle with `wr_en` high is accepted. Selector values: 0 writes the duty (`wr_data[1:0]`), 1 writes period bits 7..0 (`wr_data[7:0]`), 2 writes period bits 10..8 (`wr_data[2:0]`), and 3 is ignored.

Top module: `pulse_channel`

## Requirements
- R1: While `rst` is high, and after it, the duty, period, timer count, sequence position and half-rate phase are zero, `out` is 0 and `env_restart` is 0.
- R2: The period is {high 3 bits, low 8 bits}. The timer changes only on every second clock, counts t down to 0 and then reloads t, so one waveform lasts 16*(t+1) clocks.
- R3: The duty patterns, listed by sequence position 0 to 7, are: duty 0 = 0 1 0 0 0 0 0 0, duty 1 = 0 1 1 0 0 0 0 0, duty 2 = 0 1 1 1 1 0 0 0, duty 3 = 1 0 0 1 1 1 1 1. Over one waveform, `out` is nonzero for 2*(t+1) times the number of ones in the pattern.
- R4: The sequence position steps downward modulo 8 (0, 7, 6, ..., 1, 0) each time the timer is at zero on a half-rate tick.
- R5: A duty write changes only the pattern and leaves the sequence position where it is.
- R6: A high-period write sets the sequence position to 0 on the next cycle and raises `env_restart` for exactly that one cycle. `env_restart` is never high otherwise. A high-period write wins over a same-cycle sweep update.
- R7: A low-period write updates only the stored period. The running count continues and the new value is used at the next reload.
- R8: When the period is below 8, whether it was written or loaded through `sweep_upd`, `out` is 0.
- R9: `out` equals `vol` except that it is 0 when the current pattern bit is 0, when `sweep_mute` is high, or when `len_on` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register selector (0 duty, 1 period low, 2 period high) |
| wr_data | input | 8 | Write data |
| sweep_upd | input | 1 | Load `sweep_period` into the period |
| sweep_period | input | 11 | Period value from the sweep unit |
| sweep_mute | input | 1 | Sweep unit silences the channel |
| len_on | input | 1 | Length counter is nonzero |
| vol | input | 4 | Volume from the envelope generator |
| env_restart | output | 1 | One-cycle envelope restart pulse |
| out | output | 4 | Gated channel output |

## Verification
The assertions assume that `vol`, `len_on` and `sweep_mute` feed `out` only through combinational gating. They also assume the write strobe and sweep update are sampled only at clock edges, and that selector value 3 never alters state. The stimulus changes every input on the falling edge and holds `wr_en` and `sweep_upd` for exactly one rising edge. Each waveform measurement starts from a fresh reset, so the timer's count is known before the period is loaded.

// File: rtl/pulse_pkg.sv
package pulse_pkg;
  typedef enum logic [1:0] {
    SEL_DUTY = 2'd0,
    SEL_PLO  = 2'd1,
    SEL_PHI  = 2'd2,
    SEL_NONE = 2'd3
  } wsel_e;

  // Pattern bits indexed by sequence position (bit p = position p).
  function automatic logic [7:0] duty_mask(input logic [1:0] d);
    case (d)
      2'd0:    duty_mask = 8'b0000_0010;
      2'd1:    duty_mask = 8'b0000_0110;
      2'd2:    duty_mask = 8'b0001_1110;
      default: duty_mask = 8'b1111_1001;
    endcase
  endfunction
endpackage

// File: rtl/pulse_half_rate.sv
module pulse_half_rate (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  logic phase;
  always_ff @(posedge clk) begin
    if (rst) phase <= 1'b0;
    else     phase <= ~phase;
  end
  assign tick = phase;
endmodule

// File: rtl/pulse_regs.sv
module pulse_regs #(
  parameter int PER_W = 11,
  parameter int DAT_W = 8,
  localparam int HI_W = PER_W - DAT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [DAT_W-1:0] wr_data,
  input  logic             sweep_upd,
  input  logic [PER_W-1:0] sweep_period,
  output logic [PER_W-1:0] period,
  output logic [1:0]       duty,
  output logic             hi_wr,
  output logic             env_restart
);
  import pulse_pkg::*;

  logic lo_wr, duty_wr;
  assign hi_wr   = wr_en && (wr_sel == SEL_PHI);
  assign lo_wr   = wr_en && (wr_sel == SEL_PLO);
  assign duty_wr = wr_en && (wr_sel == SEL_DUTY);

  always_ff @(posedge clk) begin
    if (rst) begin
      period      <= '0;
      duty        <= 2'd0;
      env_restart <= 1'b0;
    end else begin
      env_restart <= hi_wr;
      if (duty_wr) duty <= wr_data[1:0];
      if (hi_wr || lo_wr) begin
        if (hi_wr) period[PER_W-1:DAT_W] <= wr_data[HI_W-1:0];
        if (lo_wr) period[DAT_W-1:0]     <= wr_data;
      end else if (sweep_upd) begin
        period <= sweep_period;
      end
    end
  end
endmodule

// File: rtl/pulse_timer.sv
module pulse_timer #(
  parameter int PER_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [PER_W-1:0] period,
  output logic [PER_W-1:0] cnt,
  output logic             step
);
  assign step = tick && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (step) cnt <= period;
    else if (tick) cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/pulse_seq.sv
module pulse_seq #(
  parameter int SEQ_LEN = 8,
  localparam int IDX_W = $clog2(SEQ_LEN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             step,
  input  logic [1:0]       duty,
  output logic [IDX_W-1:0] idx,
  output logic             bit_on
);
  import pulse_pkg::*;

  logic [SEQ_LEN-1:0] mask;
  assign mask   = duty_mask(duty);
  assign bit_on = mask[idx];

  always_ff @(posedge clk) begin
    if (rst)          idx <= '0;
    else if (restart) idx <= '0;
    else if (step)    idx <= idx - 1'b1;
  end
endmodule

// File: rtl/pulse_gate.sv
module pulse_gate #(
  parameter int PER_W   = 11,
  parameter int VOL_W   = 4,
  parameter int MIN_PER = 8
) (
  input  logic [PER_W-1:0] period,
  input  logic             bit_on,
  input  logic             sweep_mute,
  input  logic             len_on,
  input  logic [VOL_W-1:0] vol,
  output logic [VOL_W-1:0] out
);
  logic audible;
  assign audible = bit_on && !sweep_mute && len_on && (period >= PER_W'(MIN_PER));
  assign out     = audible ? vol : '0;
endmodule

// File: rtl/pulse_channel.sv
module pulse_channel #(
  parameter int PER_W   = 11,
  parameter int DAT_W   = 8,
  parameter int VOL_W   = 4,
  parameter int SEQ_LEN = 8,
  parameter int MIN_PER = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [DAT_W-1:0] wr_data,
  input  logic             sweep_upd,
  input  logic [PER_W-1:0] sweep_period,
  input  logic             sweep_mute,
  input  logic             len_on,
  input  logic [VOL_W-1:0] vol,
  output logic             env_restart,
  output logic [VOL_W-1:0] out
);
  localparam int IDX_W = $clog2(SEQ_LEN);

  logic             tick, step, hi_wr, bit_on;
  logic [PER_W-1:0] period, cnt;
  logic [1:0]       duty;
  logic [IDX_W-1:0] idx;

  pulse_half_rate u_half (.clk(clk), .rst(rst), .tick(tick));

  pulse_regs #(.PER_W(PER_W), .DAT_W(DAT_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .sweep_upd(sweep_upd), .sweep_period(sweep_period),
    .period(period), .duty(duty), .hi_wr(hi_wr), .env_restart(env_restart)
  );

  pulse_timer #(.PER_W(PER_W)) u_timer (
    .clk(clk), .rst(rst), .tick(tick), .period(period), .cnt(cnt), .step(step)
  );

  pulse_seq #(.SEQ_LEN(SEQ_LEN)) u_seq (
    .clk(clk), .rst(rst), .restart(hi_wr), .step(step), .duty(duty),
    .idx(idx), .bit_on(bit_on)
  );

  pulse_gate #(.PER_W(PER_W), .VOL_W(VOL_W), .MIN_PER(MIN_PER)) u_gate (
    .period(period), .bit_on(bit_on), .sweep_mute(sweep_mute), .len_on(len_on),
    .vol(vol), .out(out)
  );
endmodule

// File: rtl/pulse_channel_chk.sv
module pulse_channel_chk #(
  parameter int PER_W = 11,
  parameter int DAT_W = 8,
  parameter int VOL_W = 4,
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [1:0]       wr_sel,
  input logic             sweep_mute,
  input logic             len_on,
  input logic [VOL_W-1:0] vol,
  input logic             env_restart,
  input logic [VOL_W-1:0] out,
  input logic             tick,
  input logic [PER_W-1:0] cnt,
  input logic [PER_W-1:0] period,
  input logic [IDX_W-1:0] idx
);
  logic hi_w, duty_w;
  assign hi_w   = wr_en && (wr_sel == 2'd2);
  assign duty_w = wr_en && (wr_sel == 2'd0);

  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (env_restart == 1'b0)); // R1
  AST_CNT_HALF_RATE: assert property (@(posedge clk) disable iff (rst) !tick |=> $stable(cnt)); // R2
  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (rst)
    (tick && cnt == '0 && !hi_w) |=> (idx == IDX_W'($past(idx) - 1'b1))); // R4
  AST_DUTY_KEEPS_IDX: assert property (@(posedge clk) disable iff (rst)
    (duty_w && !tick) |=> $stable(idx)); // R5
  AST_HI_ZEROS_IDX: assert property (@(posedge clk) disable iff (rst) hi_w |=> (idx == '0)); // R6
  AST_RESTART_PULSE: assert property (@(posedge clk) disable iff (rst) hi_w |=> env_restart); // R6
  AST_RESTART_ONLY: assert property (@(posedge clk) disable iff (rst) !hi_w |=> !env_restart); // R6
  AST_SHORT_PERIOD_MUTE: assert property (@(posedge clk) disable iff (rst)
    (period < PER_W'(8)) |-> (out == '0)); // R8
  AST_LEN_MUTE: assert property (@(posedge clk) disable iff (rst) !len_on |-> (out == '0)); // R9
  AST_SWEEP_MUTE: assert property (@(posedge clk) disable iff (rst) sweep_mute |-> (out == '0)); // R9
  AST_OUT_IS_VOL: assert property (@(posedge clk) disable iff (rst)
    (out == '0) || (out == vol)); // R9
endmodule

bind pulse_channel pulse_channel_chk #(
  .PER_W(PER_W), .DAT_W(DAT_W), .VOL_W(VOL_W), .IDX_W($clog2(SEQ_LEN))
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .sweep_mute(sweep_mute),
  .len_on(len_on), .vol(vol), .env_restart(env_restart), .out(out),
  .tick(tick), .cnt(cnt), .period(period), .idx(idx)
);

// File: tb/pulse_channel_test.sv
`timescale 1ns/1ps
module pulse_channel_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [7:0]  wr_data = 8'd0;
  logic        sweep_upd = 1'b0;
  logic [10:0] sweep_period = 11'd0;
  logic        sweep_mute = 1'b0;
  logic        len_on = 1'b1;
  logic [3:0]  vol = 4'd0;
  logic        env_restart;
  logic [3:0]  out;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pulse_channel uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .sweep_upd(sweep_upd), .sweep_period(sweep_period), .sweep_mute(sweep_mute),
    .len_on(len_on), .vol(vol), .env_restart(env_restart), .out(out)
  );

  // {duty, period, vol, expected nonzero cycles over one waveform}
  localparam int NV = 7;
  localparam int VEC [NV][4] = '{
    '{0,    8, 15,   18},
    '{1,   10,  9,   44},
    '{2,   20,  5,  168},
    '{3,    8, 12,  108},
    '{2,    7, 10,    0},
    '{3,  300,  3, 3612},
    '{0, 1280,  7, 2562}
  };

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // Drives one write across exactly one rising edge; returns at the next falling edge.
  task automatic wr(input logic [1:0] sel, input logic [7:0] data);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    vol = 4'd9;
    // R1: reset state
    @(negedge clk);
    check("R1 out in reset", out, 0);
    check("R1 env_restart in reset", env_restart, 0);
    rst = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R1 out after reset (period 0)", out, 0);

    // R2/R3/R8: table walk, one full waveform counted after one settling waveform
    for (int v = 0; v < NV; v++) begin
      int cyc, hits;
      do_reset();
      vol = 4'(VEC[v][2]);
      wr(2'd0, 8'(VEC[v][0]));
      wr(2'd1, 8'(VEC[v][1] & 255));
      wr(2'd2, 8'(VEC[v][1] >> 8));
      cyc = 16 * (VEC[v][1] + 1);
      repeat (cyc) @(negedge clk);
      hits = 0;
      for (int k = 0; k < cyc; k++) begin
        @(negedge clk);
        if (out != 0) hits++;
      end
      check($sformatf("R2/R3/R8 vec%0d duty=%0d t=%0d", v, VEC[v][0], VEC[v][1]), hits, VEC[v][3]);
    end

    // R4 and R7: downward order, low write does not disturb running count
    begin
      int n;
      do_reset();
      vol = 4'd11;
      wr(2'd1, 8'd200);
      wr(2'd2, 8'd0);
      wr(2'd0, 8'd3);
      wr(2'd1, 8'd8);
      n = 0;
      while (out != 0 && n < 2000) begin
        @(negedge clk);
        n++;
      end
      check("R4/R7 high run length in window", int'(n >= 480 && n <= 500), 1);
      // R5: position is at 2 now; duty 2 has a one there, duty reset would give zero
      wr(2'd0, 8'd2);
      check("R5 duty write keeps position", out, 11);
    end

    // R6: restart pulse and position reset
    do_reset();
    vol = 4'd6;
    wr(2'd0, 8'd3);
    wr(2'd1, 8'd100);
    check("R6 no restart on low write", env_restart, 0);
    wr_en = 1'b1; wr_sel = 2'd2; wr_data = 8'd0;
    @(negedge clk);
    wr_en = 1'b0;
    check("R6 restart pulse high", env_restart, 1);
    check("R6 position 0 gives duty3 high", out, 6);
    @(negedge clk);
    check("R6 restart pulse one cycle", env_restart, 0);

    // R9: gating (position 0 of duty 3 is high, period 100 keeps it there)
    len_on = 1'b0; #1;
    check("R9 len_on low mutes", out, 0);
    len_on = 1'b1; #1;
    check("R9 len_on high passes vol", out, 6);
    sweep_mute = 1'b1; #1;
    check("R9 sweep_mute mutes", out, 0);
    sweep_mute = 1'b0; vol = 4'd13; #1;
    check("R9 output follows vol", out, 13);

    // R8: sweep update to short period, then back
    @(negedge clk);
    sweep_period = 11'd5; sweep_upd = 1'b1;
    @(negedge clk);
    sweep_upd = 1'b0;
    check("R8 sweep short period mutes", out, 0);
    sweep_period = 11'd8; sweep_upd = 1'b1;
    @(negedge clk);
    sweep_upd = 1'b0;
    check("R8 period 8 is audible", int'(out == 0 || out == 13), 1);
    wr(2'd1, 8'd7);
    check("R8 written period 7 mutes", out, 0);

    // R6: high write wins over same-cycle sweep update
    sweep_period = 11'd3; sweep_upd = 1'b1;
    wr(2'd2, 8'd1);
    sweep_upd = 1'b0;
    check("R6 high write wins over sweep", out, 13);

    done = 1'b1;
  end

  initial begin
    int w;
    w = 0;
    while (!done && w < 150000) begin
      @(posedge clk);
      w++;
    end
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=done", w);
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule